// File: doc/BRIEF.md
# Receive Buffer Descriptor Walker

This block takes a received Ethernet frame, presented one byte at a time with start and end markers, and spreads it over a chain of fixed-size receive buffers in memory. The buffers are located through a ring of two-word descriptors. Word 0 of a descriptor carries the word-aligned buffer address, a ring-end flag and a used flag. Word 1 receives the status. The block reaches both the descriptors and the buffers through one 32-bit memory port with byte enables. Reads on that port return data one cycle after the request.

For each frame, the block fetches the next descriptor and checks its used flag. It then fills that buffer, writes the descriptor status, and marks the descriptor used. If the frame is longer than the buffer, it moves on to the next descriptor. The first buffer of a frame may begin one to three bytes into its first word. When a fetched descriptor is still held by software, the block reports a one-cycle buffer-not-available error and discards the remainder of the frame. The ring position is kept from one frame to the next.

Top module: `rxdesc_walker`

## Requirements
- R1: After reset, the first descriptor is read from `ring_base`. Descriptor n always lies at `ring_base + 8*n`: word 0 at that address and word 1 at that address plus 4.
- R2: The descriptor after one whose word 0 has bit 1 (ring end) set is the one at `ring_base`. Otherwise the next descriptor is the following one. The position carries over between frames.
- R3: A frame byte at buffer byte offset k goes to the word at `buffer + (k & ~3)`, in lane k%4 (bits 8*(k%4)+7 down to 8*(k%4)). A word is written when lane 3 is filled or when the frame ends, with `mem_be` bit j set exactly for the lanes filled. Unfilled lanes read as zero.
- R4: The first buffer of a frame starts at byte offset `start_ofs` and holds 128 minus that many bytes. Every following buffer starts at offset 0 and holds 128 bytes.
- R5: When a buffer is closed, its status word (word 1) is written first. Word 0 is then written with bit 0 set to 1, keeping the address bits and bit 1 unchanged.
- R6: A buffer that the frame continues past gets a status word of zero, except for bit 14 (start of frame) and bits 13:12 (start offset). Those are set only on the first buffer of the frame.
- R7: The last buffer's status word holds the frame length in bytes in bits 11:0 and bit 15 set. Bits 14 and 13:12 follow R6. Bits 31..28 hold `rx_flags[3..0]` (broadcast, multicast hash, unicast hash, specific address). Bits 27:16 are zero.
- R8: If a fetched word 0 has bit 0 set, `bna_err` pulses for one cycle. Nothing more is written for that frame, the remaining bytes are accepted and dropped through the end marker, and the next frame fetches the same descriptor again.
- R9: During and right after reset, `rx_ready`, `mem_req` and `bna_err` are low.
- R10: While idle, the block keeps `rx_ready` low and makes no memory access until a byte with `rx_sof` is offered. That first byte is accepted only after the descriptor check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of descriptor 0 (8-byte aligned) |
| start_ofs | input | 2 | Byte offset of the first buffer of a frame |
| rx_valid | input | 1 | Frame byte offered |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of its frame |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_flags | input | 4 | Address-match flags, valid with `rx_eof` |
| rx_ready | output | 1 | Byte accepted this cycle when `rx_valid` is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| bna_err | output | 1 | Pulse: descriptor still owned by software |

## Verification
The frame end and the buffer-full condition can be reached by the same byte. That same byte also flushes a partly or fully packed word. The bench provokes this by sizing a frame at exactly 128 minus the start offset bytes. The scoreboard then expects three things: the last data word with all its lanes, one final status carrying the length and the end bit, and no fetch of a further descriptor. A second collision happens at a buffer boundary that lands on a descriptor still owned by software. In that case the scoreboard expects the closing writes of the filled buffer, then the error pulse, and then silence on the memory port while the remaining bytes drain.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_DATA,
    ST_STAT,
    ST_OWN,
    ST_DROP
  } walk_st_e;

  // descriptor word 0
  localparam int unsigned OWN_BIT  = 0;
  localparam int unsigned WRAP_BIT = 1;
  // descriptor word 1
  localparam int unsigned OFS_LSB  = 12;
  localparam int unsigned SOF_BIT  = 14;
  localparam int unsigned EOF_BIT  = 15;
  localparam int unsigned FLAG_LSB = 28;
endpackage

// File: rtl/rxw_ring.sv
module rxw_ring #(
  parameter int unsigned IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        advance,
  input  logic        wrap,
  output logic [31:0] desc_addr
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance) begin
      idx_d = wrap ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= idx_d;
    end
  end

  assign desc_addr = ring_base + (32'(idx_q) << 3);

  // R2: closing a ring-end descriptor points back to the base
  p_wrap_to_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (desc_addr == ring_base));
endmodule

// File: rtl/rxw_packer.sv
module rxw_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        flush,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  output logic [31:0] word_out,
  output logic [3:0]  be_out
);
  logic [31:0] word_q, word_d;
  logic [3:0]  be_q, be_d;

  always_comb begin
    word_out = word_q;
    be_out   = be_q;
    if (take) begin
      word_out[8*lane +: 8] = byte_in;
      be_out[lane]          = 1'b1;
    end
  end

  always_comb begin
    word_d = word_q;
    be_d   = be_q;
    if (take) begin
      if (flush) begin
        word_d = '0;
        be_d   = '0;
      end else begin
        word_d = word_out;
        be_d   = be_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
    end else if (take) begin
      word_q <= word_d;
      be_q   <= be_d;
    end
  end

  // R3: each lane of a word is filled at most once before the word is stored
  p_lane_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !be_q[lane]);
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned LEN_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [3:0]  rx_flags,
  input  logic [1:0]  start_ofs,
  output logic        rx_ready,
  input  logic [31:0] desc_addr,
  output logic        advance,
  output logic        wrap,
  output logic        take,
  output logic        flush,
  output logic [1:0]  lane,
  input  logic [31:0] word_in,
  input  logic [3:0]  be_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  output logic        bna_err
);
  localparam int unsigned POS_W = $clog2(BUF_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BUF_BYTES - 1);

  walk_st_e          st_q, st_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              first_q, first_d;
  logic              last_q, last_d;
  logic [31:0]       baddr_q, baddr_d;
  logic              wrap_q, wrap_d;
  logic [1:0]        ofs_q, ofs_d;
  logic [3:0]        flags_q, flags_d;
  logic [31:0]       stat_w;

  always_comb begin
    stat_w = '0;
    if (first_q) begin
      stat_w[SOF_BIT]       = 1'b1;
      stat_w[OFS_LSB +: 2]  = ofs_q;
    end
    if (last_q) begin
      stat_w[EOF_BIT]       = 1'b1;
      stat_w[LEN_W-1:0]     = len_q;
      stat_w[FLAG_LSB +: 4] = flags_q;
    end
  end

  assign lane = pos_q[1:0];
  assign wrap = wrap_q;

  always_comb begin
    st_d      = st_q;
    pos_d     = pos_q;
    len_d     = len_q;
    first_d   = first_q;
    last_d    = last_q;
    baddr_d   = baddr_q;
    wrap_d    = wrap_q;
    ofs_d     = ofs_q;
    flags_d   = flags_q;
    rx_ready  = 1'b0;
    take      = 1'b0;
    flush     = 1'b0;
    advance   = 1'b0;
    bna_err   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = '0;
    case (st_q)
      ST_IDLE: begin
        if (rx_valid && rx_sof) begin
          st_d    = ST_FETCH;
          first_d = 1'b1;
          last_d  = 1'b0;
          len_d   = '0;
          ofs_d   = start_ofs;
          pos_d   = POS_W'(start_ofs);
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        mem_be  = 4'hF;
        st_d    = ST_CHECK;
      end
      ST_CHECK: begin
        if (mem_rdata[OWN_BIT]) begin
          bna_err = 1'b1;
          st_d    = ST_DROP;
        end else begin
          baddr_d = {mem_rdata[31:2], 2'b00};
          wrap_d  = mem_rdata[WRAP_BIT];
          st_d    = ST_DATA;
        end
      end
      ST_DATA: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          take  = 1'b1;
          flush = (pos_q[1:0] == 2'b11) || rx_eof;
          pos_d = pos_q + 1'b1;
          len_d = len_q + 1'b1;
          if (flush) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = baddr_q + 32'({pos_q[POS_W-1:2], 2'b00});
            mem_wdata = word_in;
            mem_be    = be_in;
          end
          if (rx_eof) begin
            last_d  = 1'b1;
            flags_d = rx_flags;
            st_d    = ST_STAT;
          end else if (pos_q == POS_LAST) begin
            st_d = ST_STAT;
          end
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + 32'd4;
        mem_wdata = stat_w;
        mem_be    = 4'hF;
        st_d      = ST_OWN;
      end
      ST_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {baddr_q[31:2], wrap_q, 1'b1};
        mem_be    = 4'hF;
        advance   = 1'b1;
        first_d   = 1'b0;
        pos_d     = '0;
        st_d      = last_q ? ST_IDLE : ST_FETCH;
      end
      ST_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_eof) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      baddr_q <= '0;
      wrap_q  <= 1'b0;
      ofs_q   <= '0;
      flags_q <= '0;
    end else begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      first_q <= first_d;
      last_q  <= last_d;
      baddr_q <= baddr_d;
      wrap_q  <= wrap_d;
      ofs_q   <= ofs_d;
      flags_q <= flags_d;
    end
  end

  // R8: data is only accepted into a buffer whose used flag read back as zero
  p_enter_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && $past(st_q) == ST_CHECK) |-> !$past(mem_rdata[OWN_BIT]));
  // R8: an owned descriptor leads to no write in the following cycle
  p_bna_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bna_err |=> !(mem_req && mem_we));
  // R8: the error is a single-cycle pulse
  p_bna_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bna_err |=> !bna_err);
  // R5: the ownership write follows the status write of the same descriptor
  p_stat_then_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> $past(mem_req && mem_we && mem_addr == desc_addr + 32'd4));
  // R3: data writes stay inside the current buffer
  p_inside_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mem_we) |-> ((mem_addr - baddr_q) < 32'(BUF_BYTES)));
  // R10: idle means no acceptance and no memory traffic
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!rx_ready && !mem_req));
endmodule

// File: rtl/rxdesc_walker.sv
module rxdesc_walker #(
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned IDX_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic [1:0]  start_ofs,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [3:0]  rx_flags,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  output logic        bna_err
);
  logic        rst_meta, rst_sync;
  logic [31:0] desc_addr;
  logic        advance, wrap, take, flush;
  logic [1:0]  lane;
  logic [31:0] word;
  logic [3:0]  be;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rxw_ring #(.IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ring_base (ring_base),
    .advance   (advance),
    .wrap      (wrap),
    .desc_addr (desc_addr)
  );

  rxw_packer u_pack (
    .clk      (clk),
    .rst_n    (rst_sync),
    .take     (take),
    .flush    (flush),
    .lane     (lane),
    .byte_in  (rx_data),
    .word_out (word),
    .be_out   (be)
  );

  rxw_ctrl #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .rx_flags  (rx_flags),
    .start_ofs (start_ofs),
    .rx_ready  (rx_ready),
    .desc_addr (desc_addr),
    .advance   (advance),
    .wrap      (wrap),
    .take      (take),
    .flush     (flush),
    .lane      (lane),
    .word_in   (word),
    .be_in     (be),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_rdata (mem_rdata),
    .bna_err   (bna_err)
  );
endmodule

// File: tb/rxdesc_walker_test.sv
module rxdesc_walker_test;
  localparam logic [31:0] BASE = 32'h100;

  typedef struct {
    bit          bna;
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  start_ofs;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic [3:0]  rx_flags;
  logic        rx_ready, mem_req, mem_we, bna_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic        sw_we;
  logic [31:0] sw_addr, sw_data;
  logic [31:0] mem [0:1023];

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [31:0] buf_a [0:3];
  bit          own_m [0:3];
  int          idx_m = 0;

  always #2 clk = ~clk;

  rxdesc_walker uut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .start_ofs(start_ofs),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_flags(rx_flags), .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .bna_err(bna_err)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (sw_we) mem[sw_addr[11:2]] <= sw_data;
    if (mem_req && mem_we) begin
      for (int j = 0; j < 4; j++)
        if (mem_be[j]) mem[mem_addr[11:2]][8*j +: 8] <= mem_wdata[8*j +: 8];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req && mem_we) begin
        if (q.size() == 0) chk(0, "R8 unexpected write", mem_addr, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(!e.bna && mem_addr == e.a, {e.tag, " addr"}, mem_addr, e.a);
          chk(!e.bna && mem_wdata == e.d && mem_be == e.be, {e.tag, " data"},
              mem_wdata, e.d);
        end
      end
      if (bna_err) begin
        if (q.size() == 0) chk(0, "R8 unexpected error", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.bna, "R8 error pulse", 32'h1, {31'h0, e.bna});
        end
      end
    end
  end

  task automatic push(bit bna, logic [31:0] a, logic [31:0] d, logic [3:0] be, string tag);
    exp_t e;
    e.bna = bna; e.a = a; e.d = d; e.be = be; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_desc(int k, bit owned);
    @(negedge clk);
    sw_we   = 1'b1;
    sw_addr = BASE + 32'(8 * k);
    sw_data = buf_a[k] | ((k == 3) ? 32'h2 : 32'h0) | {31'h0, owned};
    own_m[k] = owned;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic frame(int n, logic [1:0] ofs, logic [3:0] fl, logic [7:0] seed);
    int pos = int'(ofs);
    bit first = 1;
    bit dead = 0;
    int cur = idx_m;
    logic [31:0] w = '0;
    logic [3:0] be = '0;
    if (own_m[cur]) begin push(1, 0, 0, 0, "R8"); dead = 1; end
    for (int i = 0; i < n && !dead; i++) begin
      int ln = pos % 4;
      bit last = (i == n - 1);
      w[8*ln +: 8] = 8'(seed + 8'(i));
      be[ln] = 1'b1;
      if (ln == 3 || last) begin
        push(0, buf_a[cur] + 32'(pos & ~3), w, be, first ? "R4 R3" : "R3");
        w = '0; be = '0;
      end
      pos++;
      if (last || pos == 128) begin
        logic [31:0] st = '0;
        if (first) begin st[14] = 1'b1; st[13:12] = ofs; end
        if (last) begin st[15] = 1'b1; st[11:0] = 12'(n); st[31:28] = fl; end
        push(0, BASE + 32'(8 * cur) + 32'd4, st, 4'hF, last ? "R5 R7" : "R5 R6");
        push(0, BASE + 32'(8 * cur), buf_a[cur] | ((cur == 3) ? 32'h2 : 32'h0) | 32'h1,
             4'hF, (cur == 0) ? "R5 R1" : "R5 R2");
        own_m[cur] = 1;
        idx_m = (cur == 3) ? 0 : cur + 1;
        if (!last) begin
          cur = idx_m; pos = 0; first = 0;
          if (own_m[cur]) begin push(1, 0, 0, 0, "R8"); dead = 1; end
        end
      end
    end
    // drive the bytes
    @(negedge clk);
    start_ofs = ofs;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == n - 1);
      rx_data  = 8'(seed + 8'(i));
      rx_flags = fl;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R3 scoreboard drained", 32'(q.size()), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_we = 1'b0; sw_addr = '0; sw_data = '0;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0; rx_flags = 0; start_ofs = 0;
    for (int k = 0; k < 4; k++) begin buf_a[k] = 32'h400 + 32'(k * 128); own_m[k] = 0; end
    repeat (3) @(negedge clk);
    chk(!rx_ready && !mem_req && !bna_err, "R9 reset outputs",
        {29'h0, rx_ready, mem_req, bna_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rx_ready && !mem_req && !bna_err, "R9 after release",
        {29'h0, rx_ready, mem_req, bna_err}, 32'h0);
    for (int k = 0; k < 4; k++) set_desc(k, 0);

    // R10: bytes without a start marker are not taken while idle
    rx_valid = 1'b1; rx_data = 8'hAA;
    repeat (3) begin
      @(negedge clk);
      chk(!rx_ready && !mem_req, "R10 idle without sof", {30'h0, rx_ready, mem_req}, 32'h0);
    end
    rx_valid = 1'b0;

    frame(10,  2'd0, 4'b1000, 8'h10);  // R1 single buffer
    frame(200, 2'd3, 4'b0101, 8'h30);  // R4 offset, spans two buffers
    frame(130, 2'd2, 4'b0010, 8'h50);  // R2 wrap, then R8 owned mid-frame
    for (int k = 0; k < 4; k++) set_desc(k, 0);
    frame(1,   2'd1, 4'b0001, 8'h70);  // single byte frame
    frame(127, 2'd1, 4'b1111, 8'h80);  // end coincides with buffer full
    set_desc(2, 1);
    frame(20,  2'd0, 4'b0100, 8'h90);  // R8 owned at start
    set_desc(2, 0);
    set_desc(0, 0);
    frame(300, 2'd0, 4'b0000, 8'hA0);  // R8 retry of same slot, R2 wrap mid-frame

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule